// File: doc/BRIEF.md
# Bounded-Noise Triangle Wave Generator

This block is a synthesizable stimulus source. It produces a clean 16-bit triangular ramp and, alongside it, a noisy copy. The ramp rises one step at a time from zero to a configurable ceiling and then falls back. Every value is held for a fixed number of enabled samples before the next step is taken.

The noisy copy is the clean value plus a pseudo-random offset of -1, 0 or +1. The offset comes from an internal 16-bit maximal-length LFSR. The offset is clamped, so the noisy copy stays within one of the clean value of the same sample and within one of its own previous value. It never wraps below zero. The block is used to feed a deterministic but jittery test pattern into downstream logic, such as filters, threshold detectors or change counters.

Both outputs are registered and advance together on each clock where the enable is high.

Top module: `trinoise_gen`

## Requirements
- R1: While reset is low, and on the first sample after release, the clean output and the noisy output are both 0.
- R2: With enable high, the clean output is held for HOLD consecutive samples (default 5). It then moves by exactly one, so between samples it never changes by more than one.
- R3: The clean output never exceeds the parameter CEIL (default 30766).
- R4: On rising, once the clean output has held CEIL for HOLD samples, its next value is CEIL-1 and the ramp keeps falling.
- R5: On falling, once the clean output has held 0 for HOLD samples, its next value is 1 and the ramp keeps rising.
- R6: The signed difference between the noisy output and the clean output of the same sample is always -1, 0 or +1.
- R7: Across one enabled sample, the noisy output changes by at most one.
- R8: The noisy output never wraps: it stays in the range 0 to CEIL+1.
- R9: On the last of the HOLD samples of each clean value, the noisy output equals the clean output.
- R10: While enable is low, both outputs keep their values and the LFSR does not advance.
- R11: Away from the forced samples of R9, all three offsets -1, 0 and +1 occur in the noisy output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| en_i | input | 1 | Sample enable; each high cycle produces one new sample |
| ramp_o | output | 16 | Clean triangular ramp |
| noisy_o | output | 16 | Ramp plus clamped noise |

## Verification
The assertions take for granted that reset is driven low from time zero. They also assume the LFSR seed parameter is non-zero and that CEIL is at least 1 and at most 65534, so CEIL+1 still fits in the output width. The bench keeps to these assumptions: it asserts reset before the first edge, keeps the default seed, and uses a small ceiling so the ramp reverses several times in a short run. Enable is toggled only between edges, so a frozen sample can be told apart from an advancing one.

// File: rtl/trinoise_pkg.sv
package trinoise_pkg;

  typedef enum logic { DIR_UP = 1'b0, DIR_DOWN = 1'b1 } ramp_dir_e;

  // two-bit signed offset: 2'b11 = -1, 2'b00 = 0, 2'b01 = +1
  typedef logic signed [1:0] offs_t;

  // Three-way pick from four random bits: take the first 2-bit code that is
  // not 3 and map 0/1/2 to -1/0/+1; two rejections in a row fall back to 0.
  function automatic offs_t pick_offset(input logic [3:0] bits);
    offs_t res;
    if (bits[1:0] != 2'd3)      res = offs_t'(bits[1:0]) - offs_t'(1);
    else if (bits[3:2] != 2'd3) res = offs_t'(bits[3:2]) - offs_t'(1);
    else                        res = offs_t'(0);
    return res;
  endfunction

endpackage

// File: rtl/tri_ramp.sv
module tri_ramp
  import trinoise_pkg::*;
#(
  parameter int W    = 16,
  parameter int CEIL = 30766,
  parameter int HOLD = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] ramp_o,
  output logic [W-1:0] ramp_nx_o,
  output logic         last_nx_o
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD - 1);
  localparam logic [W-1:0]  TOP      = W'(CEIL);

  logic [W-1:0]  ramp_q, ramp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  ramp_dir_e     dir_q, dir_d;

  always_comb begin
    ramp_d = ramp_q;
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    if (en_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_d = '0;
        if (dir_q == DIR_UP) begin
          if (ramp_q == TOP) begin
            ramp_d = ramp_q - 1'b1;
            dir_d  = DIR_DOWN;
          end else begin
            ramp_d = ramp_q + 1'b1;
          end
        end else begin
          if (ramp_q == '0) begin
            ramp_d = W'(1);
            dir_d  = DIR_UP;
          end else begin
            ramp_d = ramp_q - 1'b1;
          end
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q <= '0;
      cnt_q  <= '0;
      dir_q  <= DIR_UP;
    end else if (en_i) begin
      ramp_q <= ramp_d;
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
    end
  end

  assign ramp_o    = ramp_q;
  assign ramp_nx_o = ramp_d;
  assign last_nx_o = (cnt_d == CNT_LAST);
endmodule

// File: rtl/tri_lfsr_pick.sv
module tri_lfsr_pick
  import trinoise_pkg::*;
#(
  parameter int            LW   = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  parameter logic [LW-1:0] SEED = 16'hACE1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  output offs_t offs_o
);
  logic [LW-1:0] lfsr_q, lfsr_d;

  // Galois form, shifting right
  always_comb begin
    lfsr_d = lfsr_q >> 1;
    if (lfsr_q[0]) lfsr_d = lfsr_d ^ TAPS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lfsr_q <= SEED;
    else if (en_i) lfsr_q <= lfsr_d;
  end

  assign offs_o = pick_offset(lfsr_q[3:0]);
endmodule

// File: rtl/tri_noise_clamp.sv
module tri_noise_clamp
  import trinoise_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] ramp_nx_i,
  input  logic         last_nx_i,
  input  offs_t        offs_i,
  output logic [W-1:0] noisy_o
);
  localparam int SW = W + 2;

  logic [W-1:0]          noisy_q, noisy_d;
  logic signed [SW-1:0]  r_s, p_s, lo, hi, cand, res;

  always_comb begin
    r_s  = $signed({2'b00, ramp_nx_i});
    p_s  = $signed({2'b00, noisy_q});
    cand = r_s + $signed({{W{offs_i[1]}}, offs_i});
    lo   = r_s - SW'(1);
    if (p_s - SW'(1) > lo) lo = p_s - SW'(1);
    if (lo < 0)            lo = '0;
    hi   = r_s + SW'(1);
    if (p_s + SW'(1) < hi) hi = p_s + SW'(1);
    if (last_nx_i)         res = r_s;
    else if (cand < lo)    res = lo;
    else if (cand > hi)    res = hi;
    else                   res = cand;
    noisy_d = res[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   noisy_q <= '0;
    else if (en_i) noisy_q <= noisy_d;
  end

  assign noisy_o = noisy_q;
endmodule

// File: rtl/trinoise_gen.sv
module trinoise_gen
  import trinoise_pkg::*;
#(
  parameter int          W    = 16,
  parameter int          CEIL = 30766,
  parameter int          HOLD = 5,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] ramp_o,
  output logic [W-1:0] noisy_o
);
  logic [W-1:0] ramp_nx;
  logic         last_nx;
  offs_t        offs;

  tri_ramp #(.W(W), .CEIL(CEIL), .HOLD(HOLD)) u_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .ramp_o   (ramp_o),
    .ramp_nx_o(ramp_nx),
    .last_nx_o(last_nx)
  );

  tri_lfsr_pick #(.LW(16), .TAPS(16'hB400), .SEED(SEED)) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .offs_o(offs)
  );

  tri_noise_clamp #(.W(W)) u_clamp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .ramp_nx_i(ramp_nx),
    .last_nx_i(last_nx),
    .offs_i   (offs),
    .noisy_o  (noisy_o)
  );
endmodule

// File: rtl/trinoise_gen_chk.sv
module trinoise_gen_chk #(
  parameter int W    = 16,
  parameter int CEIL = 30766
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic [W-1:0] ramp_o,
  input logic [W-1:0] noisy_o
);
  // R2: one step at most per enabled sample
  a_r2_ramp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((int'(ramp_o) - int'($past(ramp_o))) inside {-1, 0, 1}));

  // R3: ceiling respected
  a_r3_ramp_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ramp_o) <= CEIL);

  // R6: noisy within one of clean
  a_r6_noise_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'(noisy_o) - int'(ramp_o)) inside {-1, 0, 1}));

  // R7: noisy moves by at most one per sample
  a_r7_noise_slew: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((int'(noisy_o) - int'($past(noisy_o))) inside {-1, 0, 1}));

  // R8: no wrap of the noisy output
  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(noisy_o) <= CEIL + 1);

  // R10: enable low freezes both outputs
  a_r10_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(ramp_o) && $stable(noisy_o)));
endmodule

bind trinoise_gen trinoise_gen_chk #(.W(W), .CEIL(CEIL)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .ramp_o (ramp_o),
  .noisy_o(noisy_o)
);

// File: tb/tb_trinoise_gen.sv
module tb_trinoise_gen;
  localparam int W    = 16;
  localparam int CEIL = 12;
  localparam int HOLD = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] ramp, noisy;

  always #2 clk = ~clk;

  trinoise_gen #(.W(W), .CEIL(CEIL), .HOLD(HOLD)) dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .en_i   (en),
    .ramp_o (ramp),
    .noisy_o(noisy)
  );

  int n_chk = 0, n_fail = 0;
  int m_r, m_cnt, prev_noisy, prev_ramp;
  bit m_up, done = 0;
  bit seen_m = 0, seen_z = 0, seen_p = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_r = 0; m_cnt = 0; m_up = 1; prev_noisy = 0; prev_ramp = 0;
  endtask

  task automatic cycle(input bit e);
    int pr, d;
    string tag;
    en = e;
    @(posedge clk);
    pr = m_r;
    if (e) begin
      if (m_cnt == HOLD - 1) begin
        m_cnt = 0;
        if (m_up) begin
          if (m_r == CEIL) begin m_r = m_r - 1; m_up = 0; end
          else m_r = m_r + 1;
        end else begin
          if (m_r == 0) begin m_r = 1; m_up = 1; end
          else m_r = m_r - 1;
        end
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
    @(negedge clk);
    if (pr == CEIL && m_r != pr)   tag = "R4";
    else if (pr == 0 && m_r != pr) tag = "R5";
    else                           tag = "R2";
    chk(int'(ramp) == m_r, tag, int'(ramp), m_r);
    chk(int'(ramp) <= CEIL, "R3", int'(ramp), CEIL);
    d = int'(noisy) - int'(ramp);
    chk(d >= -1 && d <= 1, "R6", int'(noisy), int'(ramp));
    chk((int'(noisy) - prev_noisy) >= -1 && (int'(noisy) - prev_noisy) <= 1,
        "R7", int'(noisy), prev_noisy);
    chk(int'(noisy) <= CEIL + 1, "R8", int'(noisy), CEIL + 1);
    if (!e) begin
      chk(int'(noisy) == prev_noisy, "R10", int'(noisy), prev_noisy);
      chk(int'(ramp) == prev_ramp, "R10", int'(ramp), prev_ramp);
    end else if (m_cnt == HOLD - 1) begin
      chk(noisy == ramp, "R9", int'(noisy), int'(ramp));
    end else begin
      if (d == -1) seen_m = 1;
      if (d == 0)  seen_z = 1;
      if (d == 1)  seen_p = 1;
    end
    prev_noisy = int'(noisy);
    prev_ramp  = int'(ramp);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk(ramp == '0, "R1", int'(ramp), 0);
    chk(noisy == '0, "R1", int'(noisy), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 300; i++) cycle(!(i % 7 == 3));
    for (int i = 0; i < 4; i++) cycle(1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ramp == '0, "R1", int'(ramp), 0);
    chk(noisy == '0, "R1", int'(noisy), 0);
    rst_n = 1'b1;
    model_reset();
    for (int i = 0; i < 150; i++) cycle(1'b1);
    chk(seen_m, "R11", int'(seen_m), 1);
    chk(seen_z, "R11", int'(seen_z), 1);
    chk(seen_p, "R11", int'(seen_p), 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule